// File: doc/BRIEF.md
# Image Window Shift and Zoom Controller

This block holds a 16×16 colour image and shows a 4×4 window of it. The image arrives one pixel per cycle in raster order. Each pixel is split into red, green and blue bytes, and each colour is held in its own memory. Once the image is complete, commands move the window origin one pixel at a time or change the zoom level. Every accepted command is followed by a burst of sixteen window pixels on the output, with a valid flag on each one.

The zoom level sets the sampling step inside the window. Level 0 samples every pixel and spans 4×4 image pixels. Level 1 samples every second pixel and spans 8×8. Level 2 samples every fourth pixel and spans the whole 16×16 image. The origin is held inside the image for every level. A shift that would cross an edge is dropped. A zoom that widens the span pulls the origin back inside the new limit. Pixels pass through unmodified.

Top module: `img_window_view`

## Requirements
- R1: After reset, in_ready is 1, busy is 0 and out_valid is 0. The window origin is (row 0, column 0) and the zoom level is 0.
- R2: A pixel is stored on each cycle with in_valid=1 and in_ready=1. Pixels are taken in raster order: pixel n goes to row n/16, column n%16, and pixel bits [23:16], [15:8] and [7:0] are red, green and blue. in_ready stays 1 until the 256th pixel is stored and then falls. Later in_valid pulses change nothing.
- R3: A command (cmd_valid=1) is accepted only when in_ready=0 and busy=0. Commands offered at any other time change nothing and produce no output.
- R4: The cmd_op encoding is 0 show, 1 up, 2 down, 3 left, 4 right, 5 zoom in (finer), 6 zoom out (coarser). Code 7 is reserved: it is ignored and starts no output.
- R5: Up and down move the origin row by −1 and +1. Left and right move the origin column by −1 and +1.
- R6: A shift is dropped when it would put the origin below 0 or above the limit 16 − 4·step. The origin then keeps its value, and the output burst still runs.
- R7: step = 1 << level, and the level runs from 0 to 2. Zoom in at level 0 and zoom out at level 2 are dropped. After a zoom, each origin coordinate above the new limit is set to that limit.
- R8: A burst carries 16 pixels in row-major order. Output k (r = k/4, c = k%4) is the stored pixel at row origin_row + r·step, column origin_col + c·step, given as {R,G,B}.
- R9: Suppose a command is accepted at clock edge E0. Then out_valid is 1 after edges E1 to E16 inclusive, and busy is 1 after edges E0 to E16. Both are 0 after E17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load pixel present |
| in_pixel | input | 24 | Load pixel {R,G,B} |
| in_ready | output | 1 | High while the image is still loading |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| busy | output | 1 | High while a burst is in progress |
| out_valid | output | 1 | Output pixel present |
| out_pixel | output | 24 | Output pixel {R,G,B} |

## Verification
The bench uses the default parameters: a 16×16 image, a 4×4 window and three zoom levels. With these, the origin limits 12, 8 and 0 all occur in one run. The bench walks the origin into the bottom edge at level 0. It also widens the zoom from an origin above the new limit, once landing at level 1 and once at level 2, so clamping is exercised at both. Every burst is checked pixel by pixel against addresses computed from the expected origin and step.

// File: rtl/wv_pkg.sv
package wv_pkg;
  typedef enum logic [2:0] {
    CMD_SHOW = 3'd0,
    CMD_UP   = 3'd1,
    CMD_DOWN = 3'd2,
    CMD_LEFT = 3'd3,
    CMD_RGHT = 3'd4,
    CMD_ZIN  = 3'd5,
    CMD_ZOUT = 3'd6,
    CMD_RSV  = 3'd7
  } cmd_e;
endpackage

// File: rtl/wv_chan_ram.sv
module wv_chan_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wv_window_ctrl.sv
module wv_window_ctrl
  import wv_pkg::*;
#(
  parameter int IMG_DIM = 16,
  parameter int WIN     = 4,
  parameter int NLVL    = 3,
  localparam int CW     = $clog2(IMG_DIM),
  localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  cmd_e          op,
  output logic [CW-1:0] org_row,
  output logic [CW-1:0] org_col,
  output logic [LW-1:0] lvl
);
  localparam logic [LW-1:0] LVL_MAX = LW'(NLVL - 1);

  function automatic logic [CW:0] lim_of(input logic [LW-1:0] l);
    return (CW+1)'(IMG_DIM - (WIN << l));
  endfunction

  logic [CW-1:0] nrow, ncol;
  logic [LW-1:0] nlvl;
  logic [CW:0]   lim_cur, lim_new;

  always_comb begin
    nrow    = org_row;
    ncol    = org_col;
    nlvl    = lvl;
    lim_cur = lim_of(lvl);
    case (op)
      CMD_UP:   if (org_row != '0) nrow = org_row - 1'b1;
      CMD_DOWN: if ({1'b0, org_row} < lim_cur) nrow = org_row + 1'b1;
      CMD_LEFT: if (org_col != '0) ncol = org_col - 1'b1;
      CMD_RGHT: if ({1'b0, org_col} < lim_cur) ncol = org_col + 1'b1;
      CMD_ZIN:  if (lvl != '0) nlvl = lvl - 1'b1;
      CMD_ZOUT: if (lvl != LVL_MAX) nlvl = lvl + 1'b1;
      default:  ;
    endcase
    lim_new = lim_of(nlvl);
    if ({1'b0, nrow} > lim_new) nrow = lim_new[CW-1:0];
    if ({1'b0, ncol} > lim_new) ncol = lim_new[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      org_row <= '0;
      org_col <= '0;
      lvl     <= '0;
    end else if (go) begin
      org_row <= nrow;
      org_col <= ncol;
      lvl     <= nlvl;
    end
  end
endmodule

// File: rtl/wv_scan_seq.sv
module wv_scan_seq #(
  parameter int IMG_DIM = 16,
  parameter int WIN     = 4,
  parameter int NLVL    = 3,
  localparam int CW     = $clog2(IMG_DIM),
  localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int AW     = 2 * CW,
  localparam int WB     = $clog2(WIN),
  localparam int IW     = 2 * WB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] org_row,
  input  logic [CW-1:0] org_col,
  input  logic [LW-1:0] lvl,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          busy
);
  localparam logic [IW-1:0] IDX_LAST = IW'(WIN * WIN - 1);

  logic          issue;
  logic [IW-1:0] idx;
  logic [WB-1:0] wr, wc;
  logic [CW-1:0] prow, pcol;

  assign wr = idx[IW-1:WB];
  assign wc = idx[WB-1:0];

  always_comb begin
    prow    = org_row + (CW'(wr) << lvl);
    pcol    = org_col + (CW'(wc) << lvl);
    rd_addr = {prow, pcol};
    rd_en   = issue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue     <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      busy      <= 1'b0;
    end else begin
      out_valid <= issue;
      if (start) begin
        issue <= 1'b1;
        idx   <= '0;
        busy  <= 1'b1;
      end else begin
        if (issue) begin
          idx <= idx + 1'b1;
          if (idx == IDX_LAST) issue <= 1'b0;
        end
        if (out_valid && !issue) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/img_window_view.sv
module img_window_view
  import wv_pkg::*;
#(
  parameter int IMG_DIM = 16,
  parameter int CH_W    = 8,
  parameter int WIN     = 4,
  parameter int NLVL    = 3,
  localparam int NCH    = 3,
  localparam int PW     = NCH * CH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] in_pixel,
  output logic          in_ready,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  output logic          busy,
  output logic          out_valid,
  output logic [PW-1:0] out_pixel
);
  localparam int CW   = $clog2(IMG_DIM);
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1;
  localparam int AW   = 2 * CW;
  localparam int NPIX = IMG_DIM * IMG_DIM;
  localparam logic [AW-1:0] LD_LAST = AW'(NPIX - 1);

  logic          ready_q;
  logic [AW-1:0] ld_addr;
  logic          wr_en;
  logic          cmd_go;
  cmd_e          op;
  logic [CW-1:0] win_row, win_col;
  logic [LW-1:0] win_lvl;
  logic          rd_en;
  logic [AW-1:0] rd_addr;

  assign in_ready = ready_q;
  assign wr_en    = in_valid && ready_q;
  assign op       = cmd_e'(cmd_op);
  assign cmd_go   = cmd_valid && !ready_q && !busy && (op != CMD_RSV);

  // load counter
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      ld_addr <= '0;
    end else if (wr_en) begin
      ld_addr <= ld_addr + 1'b1;
      if (ld_addr == LD_LAST) ready_q <= 1'b0;
    end
  end

  wv_window_ctrl #(.IMG_DIM(IMG_DIM), .WIN(WIN), .NLVL(NLVL)) u_win (
    .clk(clk), .rst(rst), .go(cmd_go), .op(op),
    .org_row(win_row), .org_col(win_col), .lvl(win_lvl)
  );

  wv_scan_seq #(.IMG_DIM(IMG_DIM), .WIN(WIN), .NLVL(NLVL)) u_seq (
    .clk(clk), .rst(rst), .start(cmd_go),
    .org_row(win_row), .org_col(win_col), .lvl(win_lvl),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .out_valid(out_valid), .busy(busy)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CH_W-1:0] rd_q;
    wv_chan_ram #(.DW(CH_W), .AW(AW)) u_ram (
      .clk(clk), .we(wr_en), .waddr(ld_addr),
      .wdata(in_pixel[PW-1-ch*CH_W -: CH_W]),
      .re(rd_en), .raddr(rd_addr), .rdata(rd_q)
    );
    assign out_pixel[PW-1-ch*CH_W -: CH_W] = rd_q;
  end
endmodule

// File: rtl/wv_check.sv
module wv_check #(
  parameter int IMG_DIM = 16,
  parameter int WIN     = 4,
  parameter int NLVL    = 3,
  localparam int CW     = $clog2(IMG_DIM),
  localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          busy,
  input logic          out_valid,
  input logic [CW-1:0] org_row,
  input logic [CW-1:0] org_col,
  input logic [LW-1:0] lvl
);
  logic [CW+2:0] lim;
  assign lim = (CW+3)'(IMG_DIM) - ((CW+3)'(WIN) << lvl);

  // R7
  lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(lvl) <= NLVL - 1);

  // R6
  org_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ((CW+3)'(org_row) <= lim) && ((CW+3)'(org_col) <= lim));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy || in_ready) |=> ($stable(org_row) && $stable(org_col) && $stable(lvl)));

  // R9
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!busy && !out_valid));

  // R5
  unit_move_chk: assert property (@(posedge clk) disable iff (rst)
    ((org_row != $past(org_row)) && (lvl == $past(lvl))) |->
      ((org_row == $past(org_row) + 1'b1) || (org_row + 1'b1 == $past(org_row))));
endmodule

bind img_window_view wv_check #(.IMG_DIM(IMG_DIM), .WIN(WIN), .NLVL(NLVL)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .busy(busy), .out_valid(out_valid),
  .org_row(win_row), .org_col(win_col), .lvl(win_lvl)
);

// File: tb/test_img_window_view.sv
module test_img_window_view;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int NVEC       = 12;

  // {op[2:0], row[3:0], col[3:0], lvl[1:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 4'd0, 4'd0, 2'd0},
    {3'd1, 4'd0, 4'd0, 2'd0},
    {3'd3, 4'd0, 4'd0, 2'd0},
    {3'd2, 4'd1, 4'd0, 2'd0},
    {3'd4, 4'd1, 4'd1, 2'd0},
    {3'd6, 4'd1, 4'd1, 2'd1},
    {3'd6, 4'd0, 4'd0, 2'd2},
    {3'd6, 4'd0, 4'd0, 2'd2},
    {3'd2, 4'd0, 4'd0, 2'd2},
    {3'd5, 4'd0, 4'd0, 2'd1},
    {3'd4, 4'd0, 4'd1, 2'd1},
    {3'd5, 4'd0, 4'd1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_pixel = '0;
  logic        in_ready;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        busy;
  logic        out_valid;
  logic [23:0] out_pixel;

  int total = 0;
  int bad   = 0;
  int vcount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  img_window_view i_img_window_view (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel),
    .in_ready(in_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .out_valid(out_valid), .out_pixel(out_pixel)
  );

  always @(negedge clk) if (out_valid) vcount++;

  function automatic logic [23:0] pix(input int idx);
    logic [7:0] b;
    b = idx[7:0];
    return {b, ~b, b ^ 8'h5A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
  endtask

  task automatic load_image(input bit poke);
    int v0;
    v0 = vcount;
    for (int i = 0; i < 256; i++) begin
      if (i % 7 == 3) begin
        in_valid = 1'b0;
        in_pixel = 24'hDEAD00;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pixel = pix(i);
      cmd_valid = poke && (i == 100);
      cmd_op = 3'd2;
      if (i == 255) check(in_ready == 1'b1, "R2 ready before last", 32'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    cmd_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready after last", 32'(in_ready), 0);
    check(vcount == v0, "R3 no output while loading", 32'(vcount - v0), 0);
  endtask

  // accept at edge E0, pixels after E1..E16, idle after E17
  task automatic run_cmd(input logic [2:0] op, input int er, input int ec, input int el,
                         input string tag, input bit poke);
    int st, r, c;
    st = 1 << el;
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy after accept"}, 32'(busy), 1);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        cmd_valid = 1'b1;
        cmd_op = 3'd4;
      end
      if (poke && k == 16) cmd_valid = 1'b0;
      r = (k - 1) / 4;
      c = (k - 1) % 4;
      check(out_valid == 1'b1, {tag, " R9 valid"}, 32'(out_valid), 1);
      check(out_pixel == pix((er + r*st) * 16 + ec + c*st), {tag, " R8 pixel"},
            32'(out_pixel), 32'(pix((er + r*st) * 16 + ec + c*st)));
    end
    @(negedge clk);
    check(out_valid == 1'b0 && busy == 1'b0, {tag, " R9 idle after burst"},
          32'({out_valid, busy}), 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", WDOG, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    @(negedge clk);
    do_reset();                    // R1
    load_image(1'b1);              // R2, R3 command during load
    // R2: writes after load must not land
    in_valid = 1'b1;
    in_pixel = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++)
      run_cmd(VEC[v][12:10], int'(VEC[v][9:6]), int'(VEC[v][5:2]), int'(VEC[v][1:0]),
              "R5 R6 R7 table", 1'b0);

    // R4: reserved code ignored
    v0 = vcount;
    cmd_valid = 1'b1;
    cmd_op = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(vcount == v0 && busy == 1'b0, "R4 reserved no burst", 32'(vcount - v0), 0);
    run_cmd(3'd0, 0, 1, 0, "R4 after reserved", 1'b0);

    // R3: command while busy ignored
    run_cmd(3'd2, 1, 1, 0, "R3 poke", 1'b1);
    run_cmd(3'd0, 1, 1, 0, "R3 after poke", 1'b0);

    // R6: walk into bottom edge at level 0 (limit 12)
    for (int k = 0; k < 13; k++)
      run_cmd(3'd2, (2 + k > 12) ? 12 : 2 + k, 1, 0, "R6 down walk", 1'b0);

    // R7: zoom out clamps row 12 to limit 8
    run_cmd(3'd6, 8, 1, 1, "R7 clamp lvl1", 1'b0);

    // R1: reset mid-state, reload, origin and zoom back to zero
    do_reset();
    load_image(1'b0);
    run_cmd(3'd0, 0, 0, 0, "R1 after reset", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule